// File: doc/BRIEF.md
# Ternary Longest-Prefix Route Lookup

This block turns a destination address into a next-hop identifier. It holds a small table of routes. Each route has a value, a care mask and a next-hop number. A mask bit of 1 means that address bit must equal the value bit. A mask bit of 0 means that bit is ignored. A prefix of length L is therefore stored with its top L mask bits set and the rest cleared. Every route is compared against the presented address in the same cycle. Among the routes that match, the one in the lowest slot wins.

Software or control logic keeps the table ordered so that longer prefixes sit in lower slots. The first hit is then the most specific route, and no prefix lengths need to be compared. A catch-all route with an all-zero mask goes in the highest slot that is used.

Routes are installed, replaced or removed one slot at a time through a write port. This can happen while lookups keep flowing. A lookup result comes out registered, one cycle after the address is presented.

Top module: `tlpm_lookup`

## Requirements
- R1: After reset every slot is empty. rs_valid, rs_hit and rs_hop are 0, and a lookup of any address misses.
- R2: A slot matches an address when, at every bit position where its mask bit is 1, the address bit equals the slot's value bit. Bits whose mask bit is 0 are ignored, and the mask need not be a contiguous prefix.
- R3: When several valid slots match, the result is the next hop of the matching slot with the lowest index.
- R4: A write with wr_en=1 replaces slot wr_idx with wr_value, wr_mask and wr_hop. Writing with wr_valid=0 empties the slot, and an empty slot never matches.
- R5: When no valid slot matches, the result has rs_hit=0 and rs_hop=0.
- R6: A lookup presented with lk_valid=1 in cycle N gives rs_valid=1 in cycle N+1. In a cycle after one without a lookup, rs_valid, rs_hit and rs_hop are all 0.
- R7: A lookup presented in the same cycle as a write sees the table as it was before that write. The write is visible to lookups from the next cycle on.
- R8: A slot with an all-zero mask matches every address. Placed in the last used slot, it acts as the default route.
- R9: With 128.9.16.0/21 in slot 0, 128.9.0.0/16 in slot 1 and 0.0.0.0/0 in slot 15, address 128.9.16.14 returns the /21 hop and 142.12.0.1 returns the default hop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| lk_valid | input | 1 | A lookup is presented this cycle |
| lk_addr | input | ADDR_W | Destination address to look up |
| wr_en | input | 1 | Write one table slot this cycle |
| wr_idx | input | $clog2(DEPTH) | Slot to write; a lower index means higher priority |
| wr_valid | input | 1 | 1 installs the route, 0 empties the slot |
| wr_value | input | ADDR_W | Route value bits |
| wr_mask | input | ADDR_W | Care mask; 1 means the bit is compared |
| wr_hop | input | HOP_W | Next hop returned on a match |
| rs_valid | output | 1 | A result is present this cycle |
| rs_hit | output | 1 | At least one valid slot matched |
| rs_hop | output | HOP_W | Next hop of the winning slot, or 0 on a miss |

## Verification
A bad stored slot cannot show at the ports until a lookup reaches it. It then shows one cycle later as a wrong hop or a wrong hit flag. For that reason the bench reads every slot it has written back through addresses chosen to land on it.

A fault in the priority chain only shows when two slots match at once. The bench therefore stacks overlapping routes: a /21 over a /16, and two catch-all routes.

A write that lands early or late only shows in a lookup issued in the same cycle as that write. The bench checks that case and then checks the very next lookup.

// File: rtl/tlpm_pkg.sv
// Shared defaults for the ternary longest-prefix lookup.
// Assumes: the top module copies these defaults into its parameters.
package tlpm_pkg;
    localparam int DEF_ADDR_W = 32;
    localparam int DEF_DEPTH  = 16;
    localparam int DEF_HOP_W  = 8;
endpackage

// File: rtl/tlpm_entry_store.sv
// Route slot storage: valid flag, value, care mask and next hop for each slot.
// Assumes: one write per cycle. Value bits where the mask is 0 are stored as
// zero, so the compare logic never sees stray don't-care data.
module tlpm_entry_store #(
    parameter int DEPTH  = tlpm_pkg::DEF_DEPTH,
    parameter int ADDR_W = tlpm_pkg::DEF_ADDR_W,
    parameter int HOP_W  = tlpm_pkg::DEF_HOP_W,
    parameter int IDX_W  = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_value,
    input  logic [ADDR_W-1:0] wr_mask,
    input  logic [HOP_W-1:0]  wr_hop,
    output logic [DEPTH-1:0]  ent_valid,
    output logic [ADDR_W-1:0] ent_value [DEPTH],
    output logic [ADDR_W-1:0] ent_mask  [DEPTH],
    output logic [HOP_W-1:0]  ent_hop   [DEPTH]
);
    for (genvar s = 0; s < DEPTH; s++) begin : g_slot
        logic sel;
        assign sel = wr_en && (wr_idx == IDX_W'(s));

        // Load one slot on a write addressed to it; clear it on reset.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ent_valid[s] <= 1'b0;
                ent_value[s] <= '0;
                ent_mask[s]  <= '0;
                ent_hop[s]   <= '0;
            end else if (sel) begin
                ent_valid[s] <= wr_valid;
                ent_value[s] <= wr_value & wr_mask;
                ent_mask[s]  <= wr_mask;
                ent_hop[s]   <= wr_hop;
            end
        end
    end

    // R4: after a write, the addressed slot holds the requested valid state.
    assert_write_lands_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ent_valid[$past(wr_idx)] == $past(wr_valid));

    // R1: the cycle after reset, no slot is valid.
    assert_reset_empty_R1: assert property (@(posedge clk)
        !rst_n |=> ent_valid == '0);
endmodule

// File: rtl/tlpm_match_array.sv
// Compares the address against every slot at once.
// Assumes: stored value bits outside the mask are zero.
// Produces one hit bit per slot.
module tlpm_match_array #(
    parameter int DEPTH  = tlpm_pkg::DEF_DEPTH,
    parameter int ADDR_W = tlpm_pkg::DEF_ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] lk_addr,
    input  logic [DEPTH-1:0]  ent_valid,
    input  logic [ADDR_W-1:0] ent_value [DEPTH],
    input  logic [ADDR_W-1:0] ent_mask  [DEPTH],
    output logic [DEPTH-1:0]  hit
);
    for (genvar s = 0; s < DEPTH; s++) begin : g_cmp
        logic [ADDR_W-1:0] diff;
        // Bits that differ where the mask says to care.
        always_comb diff = (lk_addr ^ ent_value[s]) & ent_mask[s];
        // A slot hits when it is valid and no cared bit differs.
        always_comb hit[s] = ent_valid[s] && (diff == '0);
    end

    // R4: an empty slot never reports a hit.
    assert_empty_no_hit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (hit & ~ent_valid) == '0);
endmodule

// File: rtl/tlpm_prio_select.sv
// Picks the lowest-indexed hit as a one-hot grant.
// Assumes: a lower index means a longer prefix (higher priority).
module tlpm_prio_select #(
    parameter int DEPTH = tlpm_pkg::DEF_DEPTH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DEPTH-1:0] hit,
    output logic [DEPTH-1:0] grant,
    output logic             any_hit
);
    // Scan from the top down so the lowest hit index is written last and wins.
    always_comb begin
        grant   = '0;
        any_hit = 1'b0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (hit[i]) begin
                grant    = '0;
                grant[i] = 1'b1;
                any_hit  = 1'b1;
            end
        end
    end

    // R3: the grant equals the lowest set bit of the hit vector, computed here
    // by arithmetic rather than by scanning.
    assert_lowest_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
        grant == (hit & (~hit + {{(DEPTH-1){1'b0}}, 1'b1})));

    // R3: at most one slot is granted.
    assert_single_grant_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));
endmodule

// File: rtl/tlpm_lookup.sv
// Top level of the ternary longest-prefix lookup. It ties together slot
// storage, the parallel compare, priority selection and a registered result.
// Assumes: routes are stored with the most specific prefix in the lowest slot.
// A write and a lookup in the same cycle see the old table.
module tlpm_lookup #(
    parameter int DEPTH  = tlpm_pkg::DEF_DEPTH,
    parameter int ADDR_W = tlpm_pkg::DEF_ADDR_W,
    parameter int HOP_W  = tlpm_pkg::DEF_HOP_W,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic [ADDR_W-1:0] lk_addr,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_value,
    input  logic [ADDR_W-1:0] wr_mask,
    input  logic [HOP_W-1:0]  wr_hop,
    output logic              rs_valid,
    output logic              rs_hit,
    output logic [HOP_W-1:0]  rs_hop
);
    logic [DEPTH-1:0]  ent_valid;
    logic [ADDR_W-1:0] ent_value [DEPTH];
    logic [ADDR_W-1:0] ent_mask  [DEPTH];
    logic [HOP_W-1:0]  ent_hop   [DEPTH];
    logic [DEPTH-1:0]  hit;
    logic [DEPTH-1:0]  grant;
    logic              any_hit;
    logic [HOP_W-1:0]  sel_hop;
    logic [HOP_W-1:0]  hop_terms [DEPTH];

    tlpm_entry_store #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .HOP_W(HOP_W), .IDX_W(IDX_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_valid(wr_valid),
        .wr_value(wr_value), .wr_mask(wr_mask), .wr_hop(wr_hop),
        .ent_valid(ent_valid), .ent_value(ent_value),
        .ent_mask(ent_mask), .ent_hop(ent_hop)
    );

    tlpm_match_array #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_match (
        .clk(clk), .rst_n(rst_n), .lk_addr(lk_addr),
        .ent_valid(ent_valid), .ent_value(ent_value),
        .ent_mask(ent_mask), .hit(hit)
    );

    tlpm_prio_select #(.DEPTH(DEPTH)) u_select (
        .clk(clk), .rst_n(rst_n), .hit(hit),
        .grant(grant), .any_hit(any_hit)
    );

    // Gate each slot's hop with its grant bit, ready for an AND-OR mux.
    for (genvar s = 0; s < DEPTH; s++) begin : g_hop
        always_comb hop_terms[s] = grant[s] ? ent_hop[s] : '0;
    end

    // OR the gated hops together; the one-hot grant leaves a single term.
    always_comb begin
        sel_hop = '0;
        for (int i = 0; i < DEPTH; i++) sel_hop = sel_hop | hop_terms[i];
    end

    // Register the lookup result; outputs stay zero when no lookup was made.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rs_valid <= 1'b0;
            rs_hit   <= 1'b0;
            rs_hop   <= '0;
        end else begin
            rs_valid <= lk_valid;
            rs_hit   <= lk_valid && any_hit;
            rs_hop   <= (lk_valid && any_hit) ? sel_hop : '0;
        end
    end

    // R6: a lookup yields a result in the next cycle.
    assert_result_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> rs_valid);

    // R6: no lookup means quiet outputs in the next cycle.
    assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> (!rs_valid && !rs_hit && rs_hop == '0));

    // R5: a miss carries a zero hop.
    assert_miss_hop_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rs_valid && !rs_hit) |-> rs_hop == '0);

    // R5: a hit is only flagged alongside a result.
    assert_hit_with_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rs_hit |-> rs_valid);
endmodule

// File: tb/tlpm_lookup_test.sv
`timescale 1ns/1ps
module tlpm_lookup_test;
    localparam int AW = 32;
    localparam int HW = 8;
    localparam int DP = 16;
    localparam int IW = $clog2(DP);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          lk_valid = 1'b0;
    logic [AW-1:0] lk_addr = '0;
    logic          wr_en = 1'b0;
    logic [IW-1:0] wr_idx = '0;
    logic          wr_valid = 1'b0;
    logic [AW-1:0] wr_value = '0;
    logic [AW-1:0] wr_mask = '0;
    logic [HW-1:0] wr_hop = '0;
    logic          rs_valid;
    logic          rs_hit;
    logic [HW-1:0] rs_hop;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  finished = 1'b0;

    logic          exp_hit_q  [$];
    logic [HW-1:0] exp_hop_q  [$];
    logic [AW-1:0] exp_addr_q [$];
    string         exp_req_q  [$];

    tlpm_lookup #(.DEPTH(DP), .ADDR_W(AW), .HOP_W(HW)) uut (
        .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_addr(lk_addr),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_valid(wr_valid),
        .wr_value(wr_value), .wr_mask(wr_mask), .wr_hop(wr_hop),
        .rs_valid(rs_valid), .rs_hit(rs_hit), .rs_hop(rs_hop)
    );

    always #2.5 clk = ~clk;

    function automatic logic [AW-1:0] pfx(input int len);
        return (len == 0) ? '0 : ({AW{1'b1}} << (AW - len));
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run;
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    endtask

    // Driver: install or remove one route.
    task automatic put_route(input int idx, input bit v, input logic [AW-1:0] val,
                             input logic [AW-1:0] msk, input logic [HW-1:0] hop);
        wr_en = 1'b1; wr_idx = IW'(idx); wr_valid = v;
        wr_value = val; wr_mask = msk; wr_hop = hop;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Driver: issue one lookup and push its expected result.
    task automatic look(input logic [AW-1:0] a, input bit eh, input logic [HW-1:0] ep,
                        input string req);
        lk_valid = 1'b1; lk_addr = a;
        exp_hit_q.push_back(eh); exp_hop_q.push_back(ep);
        exp_addr_q.push_back(a); exp_req_q.push_back(req);
        @(negedge clk);
        lk_valid = 1'b0;
    endtask

    task automatic drain;
        while (exp_hit_q.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    // Monitor: compare each result against the front of the scoreboard.
    always @(negedge clk) begin
        if (rst_n && rs_valid) begin
            if (exp_hit_q.size() == 0) begin
                check(1'b0, "R6", "unexpected result", 1, 0);
            end else begin
                automatic logic          eh = exp_hit_q.pop_front();
                automatic logic [HW-1:0] ep = exp_hop_q.pop_front();
                automatic logic [AW-1:0] ea = exp_addr_q.pop_front();
                automatic string         er = exp_req_q.pop_front();
                check(rs_hit == eh, er, $sformatf("hit for %08h", ea), rs_hit, eh);
                check(rs_hop == ep, er, $sformatf("hop for %08h", ea), rs_hop, ep);
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_fails++;
            $display("FAIL watchdog: actual=timeout expected=done");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs are clear while in reset.
        check(rs_valid == 1'b0 && rs_hit == 1'b0 && rs_hop == '0, "R1", "reset outputs",
              {rs_valid, rs_hit, rs_hop}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R1, R5: empty table misses with a zero hop.
        look(32'h8009100E, 1'b0, 8'h00, "R1");
        drain();

        // R9 table: /21 in slot 0, /16 in slot 1, default in slot 15.
        put_route(0,  1'b1, 32'h80091000, pfx(21), 8'h05);
        put_route(1,  1'b1, 32'h80090000, pfx(16), 8'h03);
        put_route(15, 1'b1, 32'h00000000, pfx(0),  8'h09);
        look(32'h8009100E, 1'b1, 8'h05, "R9");   // 128.9.16.14 -> /21
        look(32'h8E0C0001, 1'b1, 8'h09, "R9");   // 142.12.0.1 -> default
        look(32'h8009C801, 1'b1, 8'h03, "R3");   // only /16 and default match
        look(32'h800917FF, 1'b1, 8'h05, "R2");   // last address inside /21
        look(32'h80091800, 1'b1, 8'h03, "R2");   // first address past /21
        look(32'h12345678, 1'b1, 8'h09, "R8");   // default catches anything
        drain();

        // R6: a cycle after no lookup shows quiet outputs.
        check(rs_valid == 1'b0 && rs_hit == 1'b0 && rs_hop == '0, "R6", "idle outputs",
              {rs_valid, rs_hit, rs_hop}, 0);

        // R2: non-contiguous mask: top byte and low byte compared.
        put_route(2, 1'b1, 32'h0A000005, 32'hFF0000FF, 8'h07);
        look(32'h0A123405, 1'b1, 8'h07, "R2");
        look(32'h0A123406, 1'b1, 8'h09, "R2");
        // R3: a second default in slot 4 outranks slot 15.
        put_route(4, 1'b1, 32'h00000000, pfx(0), 8'h0B);
        look(32'h8E0C0001, 1'b1, 8'h0B, "R3");
        // R4: removing slot 4 brings back slot 15.
        put_route(4, 1'b0, 32'h00000000, pfx(0), 8'h0B);
        look(32'h8E0C0001, 1'b1, 8'h09, "R4");
        // R4, R5: removing the default makes the address miss.
        put_route(15, 1'b0, 32'h00000000, pfx(0), 8'h09);
        look(32'h8E0C0001, 1'b0, 8'h00, "R5");
        drain();

        // R7: write slot 0 in the same cycle as a lookup that hits it.
        wr_en = 1'b1; wr_idx = '0; wr_valid = 1'b1;
        wr_value = 32'h80091000; wr_mask = pfx(21); wr_hop = 8'h06;
        look(32'h8009100E, 1'b1, 8'h05, "R7");   // old contents
        wr_en = 1'b0;
        look(32'h8009100E, 1'b1, 8'h06, "R7");   // new contents
        drain();

        finish_run();
    end
endmodule